// File: doc/BRIEF.md
# Flash Program/Erase Error Flag Checker

This block sits next to a flash command engine and keeps two sticky error flags for it. On every command strobe it judges the command against an address protection boundary and, for programming commands, against the current contents of the target cell. It also collects the verify-fail pulses that the array reports after an erase or a program.

A command that breaks a protection rule does not reach the array. The erase or program strobe is withheld in the same cycle. Such a command raises the protect flag, and it also raises the verify flag, so software that reads only the verify flag still learns that the operation did not complete.

Both flags stay set until software writes a 0 to the matching bit or the block is reset. Writing a 1 to a bit leaves that flag as it is. When a set event and a clear arrive in the same cycle, the set takes priority. All pins are plain control and status signals: no stream passes through the block, so it has no handshake and no back-pressure.

Top module: `flash_err_flags`

## Requirements
- R1: An `erase_vfail` pulse makes `verify_err` read 1 from the next clock edge.
- R2: A `write_vfail` pulse makes `verify_err` read 1 from the next clock edge.
- R3: Commands use the encoding `cmd_kind` 2'b01 = erase and 2'b10 = program; 2'b00 and 2'b11 are no-ops that cause no check and no strobe. An erase or program executed with `addr_hi < protect_byte` sets both `protect_err` and `verify_err` at the next edge.
- R4: A `protect_byte` of 0 protects no address; at that value only the cell-data rule of R5 can fault a command.
- R5: A program command for which `~old_data & new_data` is nonzero sets both `protect_err` and `verify_err` at the next edge. An erase command ignores the cell data.
- R6: `array_erase_go` and `array_write_go` follow an executed erase or program in the same cycle. They stay 0 for any command that faults under R3 or R5, and for no-op codes.
- R7: When `sw_wr` is 1, a 0 in `sw_wdata` bit 0 clears `verify_err` and a 0 in bit 1 clears `protect_err` at the next edge. A 1 in either bit leaves that flag unchanged.
- R8: If a set event for a flag and a clear of that same flag fall in the same cycle, the flag is 1 after the edge.
- R9: Reset (`rst_n` = 0) forces both flags to 0. Without a set or clear event, each flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_exec | input | 1 | Command execute strobe, one cycle |
| cmd_kind | input | 2 | Command code (01 erase, 10 program) |
| addr_hi | input | ADDR_W | High part of the target address |
| protect_byte | input | ADDR_W | Protection boundary; high addresses below it are locked |
| old_data | input | DATA_W | Current cell contents at the target |
| new_data | input | DATA_W | Data to be programmed |
| erase_vfail | input | 1 | Erase-verify failure pulse from the array |
| write_vfail | input | 1 | Program-verify failure pulse from the array |
| sw_wr | input | 1 | Status write strobe |
| sw_wdata | input | 2 | Status write data (bit 0 verify, bit 1 protect) |
| verify_err | output | 1 | Sticky verify error flag |
| protect_err | output | 1 | Sticky protect error flag |
| array_erase_go | output | 1 | Erase strobe passed to the array |
| array_write_go | output | 1 | Program strobe passed to the array |

## Verification
Two functions can meet in one cycle: a flag being set and the same flag being cleared by a status write. A verify-fail pulse or a faulting command can also coincide with either of them. Directed steps line up a faulting command or a verify-fail pulse with a zero status write in the same cycle and expect the flag to read 1 afterwards. A long random phase then produces many such collisions by chance. Each cycle, a behavioural model in the bench applies set-before-clear to every event and compares both flags and both array strobes with the design.

// File: rtl/flash_err_pkg.sv
package flash_err_pkg;
  typedef enum logic [1:0] {
    CMD_NOP0  = 2'b00,
    CMD_ERASE = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_NOP3  = 2'b11
  } cmd_kind_t;

  localparam int FLAG_CNT = 2;
  localparam int FLAG_VERIFY  = 0;
  localparam int FLAG_PROTECT = 1;
endpackage

// File: rtl/flash_prot_check.sv
module flash_prot_check
  import flash_err_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              cmd_exec,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic [ADDR_W-1:0] protect_byte,
  input  logic [DATA_W-1:0] old_data,
  input  logic [DATA_W-1:0] new_data,
  output logic              fault,
  output logic              erase_ok,
  output logic              write_ok
);
  logic is_erase, is_write, area_locked, bit_unerased;

  always_comb begin
    is_erase     = cmd_exec && (cmd_kind == CMD_ERASE);
    is_write     = cmd_exec && (cmd_kind == CMD_WRITE);
    area_locked  = (addr_hi < protect_byte);
    bit_unerased = |(~old_data & new_data);
    fault        = ((is_erase || is_write) && area_locked) || (is_write && bit_unerased);
    erase_ok     = is_erase && !fault;
    write_ok     = is_write && !fault;
  end
endmodule

// File: rtl/flash_sticky_flag.sv
module flash_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr_ev,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= 1'b0;
    else if (set_ev) q <= 1'b1;
    else if (clr_ev) q <= 1'b0;
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> q);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !q);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_ev && !set_ev) |=> $stable(q));
endmodule

// File: rtl/flash_err_flags.sv
module flash_err_flags
  import flash_err_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_exec,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] addr_hi,
  input  logic [ADDR_W-1:0] protect_byte,
  input  logic [DATA_W-1:0] old_data,
  input  logic [DATA_W-1:0] new_data,
  input  logic              erase_vfail,
  input  logic              write_vfail,
  input  logic              sw_wr,
  input  logic [1:0]        sw_wdata,
  output logic              verify_err,
  output logic              protect_err,
  output logic              array_erase_go,
  output logic              array_write_go
);
  logic                fault;
  logic [FLAG_CNT-1:0] set_vec, clr_vec, flag_q;

  flash_prot_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .cmd_exec     (cmd_exec),
    .cmd_kind     (cmd_kind),
    .addr_hi      (addr_hi),
    .protect_byte (protect_byte),
    .old_data     (old_data),
    .new_data     (new_data),
    .fault        (fault),
    .erase_ok     (array_erase_go),
    .write_ok     (array_write_go)
  );

  always_comb begin
    set_vec[FLAG_VERIFY]  = erase_vfail || write_vfail || fault;
    set_vec[FLAG_PROTECT] = fault;
    clr_vec = sw_wr ? ~sw_wdata : '0;
  end

  for (genvar g = 0; g < FLAG_CNT; g++) begin : g_flag
    flash_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_ev (set_vec[g]),
      .clr_ev (clr_vec[g]),
      .q      (flag_q[g])
    );
  end

  assign verify_err  = flag_q[FLAG_VERIFY];
  assign protect_err = flag_q[FLAG_PROTECT];

  a_r1_erase_vfail: assert property (@(posedge clk) disable iff (!rst_n)
    erase_vfail |=> verify_err);
  a_r2_write_vfail: assert property (@(posedge clk) disable iff (!rst_n)
    write_vfail |=> verify_err);
  a_r3_locked_area: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exec && (cmd_kind == CMD_ERASE || cmd_kind == CMD_WRITE) && addr_hi < protect_byte)
      |=> (protect_err && verify_err));
  a_r5_unerased: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_exec && cmd_kind == CMD_WRITE && |(~old_data & new_data))
      |=> (protect_err && verify_err));
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({array_erase_go, array_write_go}) <= 1);
  a_r6_no_strobe_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_hi < protect_byte) |-> !(array_erase_go || array_write_go));
  a_r9_protect_implies_verify: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protect_err) |-> verify_err);
endmodule

// File: tb/flash_err_flags_test.sv
module flash_err_flags_test;
  localparam int AW = 8;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_exec = 0;
  logic [1:0] cmd_kind = 0;
  logic [AW-1:0] addr_hi = 0, protect_byte = 0;
  logic [DW-1:0] old_data = 0, new_data = 0;
  logic erase_vfail = 0, write_vfail = 0, sw_wr = 0;
  logic [1:0] sw_wdata = 2'b11;
  logic verify_err, protect_err, array_erase_go, array_write_go;

  int vectors = 0;
  int miscompares = 0;
  int m_ver = 0, m_prot = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_err_flags #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_exec(cmd_exec), .cmd_kind(cmd_kind),
    .addr_hi(addr_hi), .protect_byte(protect_byte), .old_data(old_data),
    .new_data(new_data), .erase_vfail(erase_vfail), .write_vfail(write_vfail),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .verify_err(verify_err),
    .protect_err(protect_err), .array_erase_go(array_erase_go),
    .array_write_go(array_write_go)
  );

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at a negedge, check strobes, advance model, check flags.
  task automatic step(string tag, bit ex, int kind, int a, int pb, int od, int nd,
                      bit ev, bit wv, bit sw, int swd);
    int flt, e_go, w_go, sv, sp;
    bit er, wr;
    cmd_exec = ex; cmd_kind = kind[1:0]; addr_hi = a[AW-1:0];
    protect_byte = pb[AW-1:0]; old_data = od[DW-1:0]; new_data = nd[DW-1:0];
    erase_vfail = ev; write_vfail = wv; sw_wr = sw; sw_wdata = swd[1:0];
    #1;
    er = ex && kind == 1;
    wr = ex && kind == 2;
    flt = ((er || wr) && a < pb) || (wr && ((~od & nd) & 8'hFF) != 0);
    e_go = er && !flt;
    w_go = wr && !flt;
    check(tag, "array_erase_go", int'(array_erase_go), e_go);
    check(tag, "array_write_go", int'(array_write_go), w_go);
    sv = ev || wv || flt;
    sp = flt;
    if (sv) m_ver = 1; else if (sw && (swd & 1) == 0) m_ver = 0;
    if (sp) m_prot = 1; else if (sw && (swd & 2) == 0) m_prot = 0;
    @(negedge clk);
    check(tag, "verify_err", int'(verify_err), m_ver);
    check(tag, "protect_err", int'(protect_err), m_prot);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", "verify_err reset", int'(verify_err), 0);
    check("R9", "protect_err reset", int'(protect_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R9");

    step("R1", 0, 0, 0, 0, 0, 0, 1, 0, 0, 3);
    idle("R9");
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 1, 0, 3);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 3);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R3", 1, 1, 8'h10, 8'h20, 0, 0, 0, 0, 0, 3);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
    step("R3", 1, 2, 8'h1F, 8'h20, 8'hFF, 8'h00, 0, 0, 0, 3);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R6", 1, 1, 8'h20, 8'h20, 0, 0, 0, 0, 0, 3);
    step("R6", 1, 2, 8'h30, 8'h20, 8'hF0, 8'h30, 0, 0, 0, 3);
    step("R4", 1, 1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 3);
    step("R4", 1, 2, 8'h00, 8'h00, 8'hFF, 8'hA5, 0, 0, 0, 3);
    step("R5", 1, 2, 8'h40, 8'h00, 8'hFE, 8'h01, 0, 0, 0, 3);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R5", 1, 1, 8'h40, 8'h00, 8'h00, 8'hFF, 0, 0, 0, 3);
    step("R3", 1, 3, 8'h00, 8'hFF, 0, 0, 0, 0, 0, 3);
    step("R3", 1, 0, 8'h00, 8'hFF, 0, 0, 0, 0, 0, 3);
    step("R8", 1, 1, 8'h01, 8'h05, 0, 0, 0, 0, 1, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 0, 1, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 1, 2);
    idle("R9");

    for (int i = 0; i < 4000; i++) begin
      int pb;
      pb = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 255));
      step("RND", $urandom_range(0, 1) == 1, int'($urandom_range(0, 3)),
           int'($urandom_range(0, 255)), pb,
           ($urandom_range(0, 1) == 1) ? 255 : int'($urandom_range(0, 255)),
           int'($urandom_range(0, 255)),
           $urandom_range(0, 15) == 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 3) == 0, int'($urandom_range(0, 3)));
    end

    rst_n = 1'b0;
    m_ver = 0; m_prot = 0;
    #1;
    check("R9", "verify_err async reset", int'(verify_err), 0);
    check("R9", "protect_err async reset", int'(protect_err), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule